// File: doc/BRIEF.md
# Serially Configured Sum-of-Products Logic Array

This block is a small programmable logic array. Eight combinational inputs feed an AND plane that builds a parameterised number of product terms, eight by default. Each input offers both its true and its inverted literal to every term. An OR plane then merges any subset of those terms into each of four outputs. Once it is loaded, the array has no clocked element between the inputs and the outputs.

Every crosspoint of both planes is one bit of a single shift chain. The chain is loaded one bit per rising edge of a dedicated programming clock, from a one-bit data pin. An output-enable pin gates the four function outputs. The upper bits of the eight-bit output port are tied low. An active-low asynchronous reset clears the chain, which leaves the array with no connections. Users shift in a complete configuration of CHAIN_LEN = 2·N_IN·N_TERM + N_TERM·N_OUT bits and then raise the enable.

Top module: `sop_array`

## Requirements
- R1: On each rising edge of `cfg_clk`, the chain takes `cfg_din` into its lowest position and moves every other bit one place up, so the first bit of a CHAIN_LEN-bit load ends up at the highest position.
- R2: Number the bits of a full load by stream position s, where s=0 is the first bit shifted in. Position s = p·16 + 2·i + k selects input i for term p, with k=0 for the true literal and k=1 for the inverted one. Position s = 128 + o·8 + p connects term p to output o. A 1 makes the connection and a 0 leaves it open.
- R3: A term is the AND of its connected literals. A term with no connected literals is 0, and so is a term that holds a literal together with its own inverse.
- R4: Function output o is the OR of the terms connected to it. An output with no connected terms is 0, and a term that feeds no output has no visible effect.
- R5: While `out_en` is 0, `data_out` is all zeros whatever the inputs and configuration are. While it is 1, `data_out[3:0]` carry the four functions.
- R6: `data_out[7:4]` are always 0.
- R7: The outputs follow `data_in` combinationally, with no `cfg_clk` edge between an input change and the output change.
- R8: While `rst_n` is 0, the chain is all zeros, so `data_out` is 0 even with `out_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Programming clock; the chain shifts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of the chain |
| cfg_din | input | 1 | Serial configuration data |
| out_en | input | 1 | Output enable; high passes the functions through |
| data_in | input | 8 | Combinational inputs |
| data_out | output | 8 | Function outputs on [3:0], zero on [7:4] |

## Verification
A first configuration holds an inverted single literal, a two-literal mix, a five-input AND, an exclusive-OR built from two terms, a self-contradicting term, an empty term and a term that feeds no output. All 256 input values are swept through it with the programming clock held still. This tells apart literal polarity, AND versus OR combination, empty-term handling and true combinational response. The outputs are also compared against the model after every single shift during loading. An asymmetric second configuration and one extra shifted bit expose a reversed or misplaced chain order. Toggling the enable and resetting the chain part-way through a load show the gating and the clear.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Stream position of an AND-plane bit: term p, literal l (l = 2*input + invert).
  function automatic int unsigned and_stream_pos(input int unsigned n_in,
                                                 input int unsigned p,
                                                 input int unsigned l);
    return p * 2 * n_in + l;
  endfunction

  // Stream position of an OR-plane bit: output o, term p.
  function automatic int unsigned or_stream_pos(input int unsigned n_in,
                                                input int unsigned n_term,
                                                input int unsigned o,
                                                input int unsigned p);
    return 2 * n_in * n_term + o * n_term + p;
  endfunction

  // The first bit shifted in lands at the top of the chain.
  function automatic int unsigned stream_to_idx(input int unsigned len,
                                                input int unsigned s);
    return len - 1 - s;
  endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int unsigned LEN = 160
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  output logic [LEN-1:0] chain_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LEN-2:0], din};
  end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned N_TERM = 8
) (
  input  logic [N_IN-1:0]                  x,
  input  logic [N_TERM-1:0][2*N_IN-1:0]    mask,
  output logic [N_TERM-1:0]                term_val,
  output logic [N_TERM-1:0]                term_empty
);

  localparam int unsigned LIT_W = 2 * N_IN;

  logic [LIT_W-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = x[i];
    assign lit[2*i+1] = ~x[i];
  end

  for (genvar p = 0; p < N_TERM; p++) begin : g_term
    assign term_empty[p] = ~|mask[p];
    assign term_val[p]   = ~term_empty[p] & (&(lit | ~mask[p]));
  end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 4
) (
  input  logic [N_TERM-1:0]             term_val,
  input  logic [N_OUT-1:0][N_TERM-1:0]  mask,
  output logic [N_OUT-1:0]              sum
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    assign sum[o] = |(mask[o] & term_val);
  end

endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned PORT_W = 8
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              cfg_din,
  input  logic              out_en,
  input  logic [N_IN-1:0]   data_in,
  output logic [PORT_W-1:0] data_out
);

  localparam int unsigned LIT_W     = 2 * N_IN;
  localparam int unsigned AND_BITS  = LIT_W * N_TERM;
  localparam int unsigned OR_BITS   = N_TERM * N_OUT;
  localparam int unsigned CHAIN_LEN = AND_BITS + OR_BITS;

  logic [CHAIN_LEN-1:0]             chain_q;
  logic [N_TERM-1:0][LIT_W-1:0]     and_mask;
  logic [N_OUT-1:0][N_TERM-1:0]     or_mask;
  logic [N_TERM-1:0]                term_val;
  logic [N_TERM-1:0]                term_empty;
  logic [N_OUT-1:0]                 sum_w;

  sop_cfg_chain #(.LEN(CHAIN_LEN)) i_chain (
    .clk     (cfg_clk),
    .rst_n   (rst_n),
    .din     (cfg_din),
    .chain_q (chain_q)
  );

  // Unpack the chain into the two crosspoint planes (R2).
  for (genvar p = 0; p < N_TERM; p++) begin : g_and_map
    for (genvar l = 0; l < LIT_W; l++) begin : g_lit
      assign and_mask[p][l] =
        chain_q[sop_pkg::stream_to_idx(CHAIN_LEN, sop_pkg::and_stream_pos(N_IN, p, l))];
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_or_map
    for (genvar p = 0; p < N_TERM; p++) begin : g_term
      assign or_mask[o][p] =
        chain_q[sop_pkg::stream_to_idx(CHAIN_LEN, sop_pkg::or_stream_pos(N_IN, N_TERM, o, p))];
    end
  end

  sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) i_and (
    .x          (data_in),
    .mask       (and_mask),
    .term_val   (term_val),
    .term_empty (term_empty)
  );

  sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) i_or (
    .term_val (term_val),
    .mask     (or_mask),
    .sum      (sum_w)
  );

  assign data_out[N_OUT-1:0] = out_en ? sum_w : '0;

  if (PORT_W > N_OUT) begin : g_tie
    assign data_out[PORT_W-1:N_OUT] = '0;
  end

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned LEN    = 160
) (
  input logic              cfg_clk,
  input logic              rst_n,
  input logic              cfg_din,
  input logic              out_en,
  input logic [LEN-1:0]    chain_q,
  input logic [N_TERM-1:0] term_val,
  input logic [N_TERM-1:0] term_empty,
  input logic [PORT_W-1:0] data_out
);

  assert_shift_in_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    1'b1 |=> chain_q[0] == $past(cfg_din));

  assert_shift_move_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    1'b1 |=> chain_q[LEN-1:1] == $past(chain_q[LEN-2:0]));

  assert_empty_term_low_R3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (term_val & term_empty) == '0);

  assert_out_needs_term_R4: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (data_out[N_OUT-1:0] != '0) |-> (term_val != '0));

  assert_gate_off_R5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !out_en |-> data_out[N_OUT-1:0] == '0);

  if (PORT_W > N_OUT) begin : g_upper
    assert_upper_zero_R6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      data_out[PORT_W-1:N_OUT] == '0);
  end

endmodule

bind sop_array sop_array_chk #(
  .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .PORT_W(PORT_W), .LEN(CHAIN_LEN)
) i_chk (
  .cfg_clk    (cfg_clk),
  .rst_n      (rst_n),
  .cfg_din    (cfg_din),
  .out_en     (out_en),
  .chain_q    (chain_q),
  .term_val   (term_val),
  .term_empty (term_empty),
  .data_out   (data_out)
);

// File: tb/test_sop_array.sv
module test_sop_array;

  localparam int NI = 8;
  localparam int NT = 8;
  localparam int NO = 4;
  localparam int L  = 2 * NI * NT + NT * NO;

  logic       tck = 1'b0;
  logic       gate = 1'b0;
  logic       cfg_clk;
  logic       rst_n = 1'b0;
  logic       cfg_din = 1'b0;
  logic       out_en = 1'b1;
  logic [7:0] data_in = 8'hA5;
  logic [7:0] data_out;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  bit mq[$];        // last L shifted bits, mq[0] the oldest
  bit cfg[L];       // configuration under construction, by stream position

  assign cfg_clk = tck & gate;

  always #4 tck = ~tck;   // 125 MHz

  sop_array i_sop_array (
    .cfg_clk  (cfg_clk),
    .rst_n    (rst_n),
    .cfg_din  (cfg_din),
    .out_en   (out_en),
    .data_in  (data_in),
    .data_out (data_out)
  );

  function automatic logic [7:0] model_out();
    logic [3:0] r = 4'b0;
    bit t[NT];
    for (int p = 0; p < NT; p++) begin
      bit any = 0;
      bit v = 1;
      for (int k = 0; k < 2 * NI; k++) begin
        if (mq[p * 16 + k]) begin
          any = 1;
          if (k % 2 == 1) v = v & ~data_in[k / 2];
          else            v = v & data_in[k / 2];
        end
      end
      t[p] = any && v;
    end
    for (int o = 0; o < NO; o++)
      for (int p = 0; p < NT; p++)
        if (mq[128 + o * 8 + p] && t[p]) r[o] = 1'b1;
    return out_en ? {4'b0000, r} : 8'h00;
  endfunction

  task automatic check(input string tag);
    logic [7:0] exp_v;
    exp_v = model_out();
    n_run++;
    if (data_out !== exp_v) begin
      n_fail++;
      $display("FAIL %s: data_out=%h expected %h (data_in=%h en=%0b)",
               tag, data_out, exp_v, data_in, out_en);
    end
  endtask

  task automatic model_clear();
    mq.delete();
    for (int s = 0; s < L; s++) mq.push_back(1'b0);
  endtask

  task automatic shift_bit(input bit b, input string tag);
    @(negedge tck);
    cfg_din = b;
    gate = 1'b1;
    @(posedge tck);
    mq.push_back(b);
    void'(mq.pop_front());
    @(negedge tck);
    gate = 1'b0;
    #1 check(tag);
  endtask

  task automatic load_cfg();
    for (int s = 0; s < L; s++) shift_bit(cfg[s], "R2 load");
  endtask

  task automatic cfg_clear();
    for (int s = 0; s < L; s++) cfg[s] = 1'b0;
  endtask

  task automatic lit(input int p, input int i, input bit inv);
    cfg[p * 16 + 2 * i + (inv ? 1 : 0)] = 1'b1;
  endtask

  task automatic con(input int o, input int p);
    cfg[128 + o * 8 + p] = 1'b1;
  endtask

  task automatic apply_in(input logic [7:0] v, input string tag);
    @(negedge tck);
    data_in = v;
    #1 check(tag);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge tck);
      cycles++;
      if (cycles > 150000) begin
        n_run++;
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    model_clear();
    repeat (3) @(negedge tck);
    #1 check("R8 in reset");
    rst_n = 1'b1;
    #1 check("R8 after reset");

    // Config A
    cfg_clear();
    lit(0, 0, 1);                              con(0, 0);   // ~I0
    lit(1, 1, 0); lit(1, 2, 1);                con(0, 1);   // I1 & ~I2
    for (int i = 3; i < 8; i++) lit(2, i, 0);  con(1, 2);   // I3..I7
    lit(3, 0, 0); lit(3, 1, 1);                con(2, 3);   // I0 & ~I1
    lit(4, 0, 1); lit(4, 1, 0);                con(2, 4);   // ~I0 & I1
    lit(5, 2, 0); lit(5, 2, 1);                con(3, 5);   // contradiction
                                               con(3, 6);   // empty term
    lit(7, 7, 0);                                           // feeds nothing
    load_cfg();

    // Sweep with no programming clock (R3 R4 R7)
    for (int v = 0; v < 256; v++) apply_in(v[7:0], "R4 R3 R7 sweep");

    apply_in(8'hFF, "R6 all ones");
    n_run++;
    if (data_out[7:4] !== 4'b0000) begin
      n_fail++;
      $display("FAIL R6: data_out[7:4]=%h expected 0", data_out[7:4]);
    end

    // Enable gating
    @(negedge tck); out_en = 1'b0;
    #1 check("R5 disabled");
    apply_in(8'h00, "R5 disabled");
    apply_in(8'hF9, "R5 disabled");
    n_run++;
    if (data_out !== 8'h00) begin
      n_fail++;
      $display("FAIL R5: data_out=%h expected 00", data_out);
    end
    @(negedge tck); out_en = 1'b1;
    #1 check("R5 enabled");

    // Config B: asymmetric, order sensitive
    cfg_clear();
    lit(0, 0, 0); lit(0, 7, 0);
    for (int o = 0; o < 4; o++) con(o, 0);     // I0 & I7 everywhere
    lit(6, 6, 1); con(3, 6);                   // ~I6 -> O3
    load_cfg();
    apply_in(8'h81, "R2 order");
    apply_in(8'h80, "R2 order");
    apply_in(8'hC1, "R2 order");
    apply_in(8'h40, "R2 order");

    // One extra shift moves the whole configuration (R1)
    shift_bit(1'b1, "R1 extra shift");
    apply_in(8'h81, "R1 after shift");
    apply_in(8'h01, "R1 after shift");
    apply_in(8'h00, "R1 after shift");

    // Reset in the middle of a load (R8)
    for (int s = 0; s < 40; s++) shift_bit(cfg[s], "R1 partial");
    @(negedge tck); rst_n = 1'b0;
    model_clear();
    #1 check("R8 mid-load reset");
    apply_in(8'hFF, "R8 held in reset");
    @(negedge tck); rst_n = 1'b1;
    #1 check("R8 released");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule